// File: doc/BRIEF.md
# Input-Gated Period Timer

This block is a period timer whose counter only advances while an external gate pin sits at its active level. A polarity control picks whether a high or a low level on the pin is active. The pin passes through a register chain before use, so the pin may be fully asynchronous to the timer clock. A prescaler turns the clock into a count tick once every 2^N enabled clocks. On every tick where the gate is active, the counter goes up by one.

When a tick finds the counter equal to the compare value, the period ends. The counter reloads with one and a sticky interrupt flag is set. The flag stays set until a clear strobe removes it. Software may preload the counter before enabling the timer. That preload shapes only the first period, because every later period restarts from one. The counter resets to zero, so an untouched first period runs one tick longer than the periods after it.

The block suits measuring how long a pin dwells in one state and raising an interrupt once that time reaches a programmed amount.

Top module: `gated_period_timer`

## Requirements
- R1: After reset the count output is 0, irq is 0 and the compare register holds all ones.
- R2: While enable is 1, a tick occurs on every 2^prescale_sel-th enabled clock, counting from the clock edge at which enable rises; prescale_sel = 0 ticks on every clock. While enable is 0 no tick occurs, the prescaler restarts from zero and the count holds.
- R3: gate_pol = 1 makes a high gate level active and gate_pol = 0 makes a low level active. A tick with the gate active and no match adds exactly one to the count. A tick with the gate inactive and no match leaves the count unchanged.
- R4: gate_in passes through two clock registers. A level change applied between edges k-1 and k first affects counting at edge k+2.
- R5: A tick that finds count equal to compare ends the period, and the count becomes 1. This holds whether the gate is active or inactive on that tick.
- R6: A period end sets the irq flag, and the flag stays 1 until flag_clr is pulsed. If a period end and flag_clr fall on the same edge, the flag ends up set.
- R7: A cnt_wr pulse loads cnt_wdata into the counter and takes priority over a tick on the same edge. A preloaded value affects only the first period, because later periods restart at 1.
- R8: A cmp_wr pulse loads cmp_wdata into the compare register, and that value is the one matched from the next tick onward.
- R9: When the compare value differs, a tick with the gate active at count all-ones wraps the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the prescaler and counter |
| prescale_sel | input | 4 | Tick divider exponent, tick every 2^sel clocks |
| gate_pol | input | 1 | 1: gate active high, 0: gate active low |
| gate_in | input | 1 | Asynchronous gate pin |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 32 | Value loaded by cnt_wr |
| cmp_wr | input | 1 | Load strobe for the compare register |
| cmp_wdata | input | 32 | Value loaded by cmp_wr |
| flag_clr | input | 1 | Clears the interrupt flag |
| count | output | 32 | Current counter value |
| irq | output | 1 | Sticky period-end flag |

## Verification
The assertions assume that cnt_wr is the only thing besides a tick that moves the count. They also assume that the gate as seen by the counter is the synchronised level, never the raw pin. The stimulus changes gate_in and the polarity only on falling clock edges while the timer is disabled. It then waits several clocks so that the synchroniser has settled before any tick is counted. The one exception is the latency test, which moves the pin during counting on purpose and samples edge by edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_LOAD   = 2'd3
  } cnt_act_e;

  // Counter action priority: software load, then period end, then step.
  function automatic cnt_act_e pick_action(input logic wr, input logic tick,
                                           input logic hit, input logic active);
    cnt_act_e a;
    if (wr)                  a = ACT_LOAD;
    else if (tick && hit)    a = ACT_RELOAD;
    else if (tick && active) a = ACT_STEP;
    else                     a = ACT_HOLD;
    return a;
  endfunction

endpackage

// File: rtl/gpt_gate_sync.sv
module gpt_gate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic active
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign active = (chain[STAGES-1] == pol);
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned DIV_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;

  // Mask with the low 'sel' bits set.
  function automatic logic [DIV_W-1:0] low_mask(input logic [SEL_W-1:0] s);
    logic [DIV_W-1:0] m;
    for (int i = 0; i < DIV_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  logic [DIV_W-1:0] mask;
  assign mask = low_mask(sel);
  assign tick = enable && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (!enable) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  localparam logic [CNT_W-1:0] RELOAD_VAL = CNT_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             period_end
);
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_d;
  cnt_act_e act;

  function automatic logic [CNT_W-1:0] next_count(input cnt_act_e a,
      input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] wdata);
    logic [CNT_W-1:0] n;
    case (a)
      ACT_LOAD:   n = wdata;
      ACT_RELOAD: n = RELOAD_VAL;
      ACT_STEP:   n = cur + 1'b1;
      default:    n = cur;
    endcase
    return n;
  endfunction

  assign act        = pick_action(cnt_wr, tick, cnt_q == cmp_q, active);
  assign period_end = (act == ACT_RELOAD);
  assign cnt_d      = next_count(act, cnt_q, cnt_wdata);
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_wr) cmp_q <= cmp_wdata;
    end
  end
endmodule

// File: rtl/gpt_flag.sv
module gpt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescale_sel,
  input  logic             gate_pol,
  input  logic             gate_in,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic tick_w;
  logic gate_active_w;
  logic period_end_w;

  gpt_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(gate_in), .pol(gate_pol), .active(gate_active_w)
  );

  gpt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sel(prescale_sel), .tick(tick_w)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .active(gate_active_w),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .count(count), .period_end(period_end_w)
  );

  gpt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(period_end_w), .clr(flag_clr), .flag(irq)
  );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cnt_wr,
  input logic             flag_clr,
  input logic             tick,
  input logic             gate_active,
  input logic             period_end,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  p_tick_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> enable);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cnt_wr) |=> $stable(count));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gate_active && !period_end && !cnt_wr) |=> count == $past(count) + 1'b1);

  p_inactive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate_active && !period_end && !cnt_wr) |=> $stable(count));

  p_reload_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> count == CNT_W'(1));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> irq);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flag_clr) |=> irq);

  p_no_end_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> tick);
endmodule

bind gated_period_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_wr(cnt_wr), .flag_clr(flag_clr),
  .tick(tick_w), .gate_active(gate_active_w), .period_end(period_end_w),
  .count(count), .irq(irq)
);

// File: tb/gated_period_timer_tb.sv
`timescale 1ns/1ps
module gated_period_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  prescale_sel = '0;
  logic        gate_pol = 1'b1;
  logic        gate_in = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic        cmp_wr = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] count;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_period_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale_sel(prescale_sel),
    .gate_pol(gate_pol), .gate_in(gate_in), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
    .count(count), .irq(irq)
  );

  typedef struct packed {
    logic        pol;
    logic        gate;
    logic [3:0]  sel;
    logic [31:0] init;
    logic [31:0] cmp;
    logic [15:0] ncyc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'd0, 32'd0,          32'd10,  16'd5},   // R3 active high
    '{1'b0, 1'b0, 4'd0, 32'd0,          32'd3,   16'd9},   // R3 active low, R5 repeats
    '{1'b1, 1'b0, 4'd0, 32'd4,          32'd10,  16'd20},  // R3 inactive hold
    '{1'b1, 1'b1, 4'd2, 32'd0,          32'd100, 16'd20},  // R2 divide by 4
    '{1'b1, 1'b1, 4'd3, 32'd5,          32'd7,   16'd40},  // R7 preload, R2 divide by 8
    '{1'b0, 1'b1, 4'd1, 32'd6,          32'd6,   16'd8},   // R5 match with gate inactive
    '{1'b1, 1'b1, 4'd0, 32'hFFFF_FFFE,  32'd3,   16'd2},   // R9 wrap
    '{1'b1, 1'b1, 4'd0, 32'd0,          32'd0,   16'd3}    // R8 compare zero
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reference: tick count from the requirement, then per-tick rule.
  function automatic logic [32:0] model(input vec_t v);
    logic [31:0] c = v.init;
    logic        f = 1'b0;
    int          t = int'(v.ncyc) >> v.sel;
    bit          act = (v.gate == v.pol);
    for (int k = 0; k < t; k++) begin
      if (c == v.cmp) begin c = 32'd1; f = 1'b1; end
      else if (act)   c = c + 32'd1;
    end
    return {f, c};
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    logic [32:0] e;
    @(negedge clk);
    enable = 0; gate_pol = v.pol; gate_in = v.gate; prescale_sel = v.sel;
    repeat (4) @(negedge clk);
    cnt_wr = 1; cnt_wdata = v.init; cmp_wr = 1; cmp_wdata = v.cmp; flag_clr = 1;
    @(negedge clk);
    cnt_wr = 0; cmp_wr = 0; flag_clr = 0;
    enable = 1;
    repeat (int'(v.ncyc)) @(negedge clk);
    enable = 0;
    e = model(v);
    check($sformatf("R3/R5 vec%0d count", idx), count, e[31:0]);
    check($sformatf("R6 vec%0d irq", idx), {31'd0, irq}, {31'd0, e[32]});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", count, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    // R1 compare resets to all ones: enable, no match before count reaches it
    gate_pol = 1; gate_in = 1;
    repeat (4) @(negedge clk);
    enable = 1;
    repeat (6) @(negedge clk);
    enable = 0;
    check("R1 compare all ones", count, 32'd6);
    check("R1 no early irq", {31'd0, irq}, 32'd0);
    // R2 hold while disabled
    repeat (5) @(negedge clk);
    check("R2 hold disabled", count, 32'd6);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R6 sticky flag with enable low, then clear
    repeat (5) @(negedge clk);
    check("R6 sticky", {31'd0, irq}, 32'd1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R6 cleared", {31'd0, irq}, 32'd0);

    // R4 synchroniser latency
    gate_pol = 1; gate_in = 0; prescale_sel = 0;
    cnt_wr = 1; cnt_wdata = 32'd20; cmp_wr = 1; cmp_wdata = 32'd1000;
    @(negedge clk);
    cnt_wr = 0; cmp_wr = 0;
    repeat (3) @(negedge clk);
    enable = 1;
    repeat (2) @(negedge clk);
    check("R4 idle gate", count, 32'd20);
    gate_in = 1;
    @(negedge clk);
    check("R4 edge1", count, 32'd20);
    @(negedge clk);
    check("R4 edge2", count, 32'd20);
    @(negedge clk);
    check("R4 edge3", count, 32'd21);

    // R7 write beats tick while running
    cnt_wr = 1; cnt_wdata = 32'd500;
    @(negedge clk);
    cnt_wr = 0;
    check("R7 load priority", count, 32'd500);
    @(negedge clk);
    check("R7 step after load", count, 32'd501);
    enable = 0;

    // R6 set wins over clear on the same edge
    cnt_wr = 1; cnt_wdata = 32'd9; cmp_wr = 1; cmp_wdata = 32'd9;
    @(negedge clk);
    cnt_wr = 0; cmp_wr = 0;
    enable = 1; flag_clr = 1;
    @(negedge clk);
    enable = 0; flag_clr = 0;
    check("R6 set over clear", {31'd0, irq}, 32'd1);
    check("R5 reload one", count, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule